// File: doc/BRIEF.md
# Serial Core Operating-State Controller

This block holds the operating state of a serial protocol core: held in reset, running, or paused. Software selects a state by writing the state register. The block reports the current state with a settled flag. After every accepted change that flag stays low for a fixed settling time. Software polls the flag before it issues the next request, then polls again until the flag is high and the requested state is shown.

The block drives three qualifier outputs for the command engine downstream. Run lets the engine consume queued commands. Hold freezes the engine while software refills its output queue. Clear empties the engine. A second, write-only register gives a software reset: it returns the whole controller to the reset state and runs the settling sequence again.

Requests that break the transition rules are dropped and recorded in a sticky error bit. So are requests that arrive while a change is still settling.

Top module: `op_state_ctrl`

## Requirements
- R1: After asynchronous reset (rst_ni low), the state register reads 0x14: state reset, settled bit high, core-ready bit high, error bit low. engine_clear_o is high.
- R2: Reading word address 0 returns the state in bits [1:0] (reset = 0, run = 1, pause = 3), the settled bit in bit 2, the core-ready bit in bit 4 and the sticky error bit in bit 8; every other bit reads 0. Any other address reads 0, including the write-only software-reset register at address 1.
- R3: An accepted write shows the target state in the cycle after the write edge. The settled bit is then low for exactly SETTLE_CYC (default 4) sampled cycles before it returns high.
- R4: Legal transitions are: to reset from any state; to run from reset, run or pause; to pause only from run.
- R5: An illegal request is ignored and sets the error bit. Illegal requests are pause from reset, pause from pause, and the unused code 2. When one is ignored, the state is kept and the settled bit stays high.
- R6: A write to the state register while the settled bit is low is ignored (the pending state is kept) and sets the error bit.
- R7: Writing 1 in bit 0 of address 1 forces the reset state, clears the error and core-ready bits, and restarts the settling window, even while busy. Core-ready returns together with the settled bit. The same write with bit 0 = 0 has no effect.
- R8: The core-ready bit stays high through run and pause transitions. Only a software reset clears it.
- R9: engine_run_o, engine_hold_o and engine_clear_o are high only while the settled bit is high and the state is run, pause or reset, respectively. At most one of them is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Word address for the access |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data for reg_addr_i, combinational |
| engine_run_o | output | 1 | Engine may consume commands |
| engine_hold_o | output | 1 | Engine frozen for queue refill |
| engine_clear_o | output | 1 | Engine held clear |

## Verification
A write is sampled on a rising edge, and its effect on the read data and the engine qualifiers is due at the falling edge of the same cycle. The settled bit and the qualifiers come back high at the falling edge that follows SETTLE_CYC further rising edges. The bench drives inputs just after each rising edge and compares against its own model at every falling edge. Directed checks count the falling edges at which the settled bit is low after each transition, so an off-by-one settling window is reported.

// File: rtl/op_state_pkg.sv
package op_state_pkg;
  typedef enum logic [1:0] {
    ST_RESET = 2'd0,
    ST_RUN   = 2'd1,
    ST_RSVD  = 2'd2,
    ST_PAUSE = 2'd3
  } op_state_e;

  localparam int unsigned VALID_BIT = 2;
  localparam int unsigned READY_BIT = 4;
  localparam int unsigned ERR_BIT   = 8;
endpackage

// File: rtl/op_state_legal.sv
module op_state_legal
  import op_state_pkg::*;
(
  input  op_state_e cur_i,
  input  op_state_e req_i,
  output logic      legal_o
);
  always_comb begin
    unique case (req_i)
      ST_RESET: legal_o = 1'b1;
      ST_RUN:   legal_o = (cur_i != ST_RSVD);
      ST_PAUSE: legal_o = (cur_i == ST_RUN);
      default:  legal_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/op_state_settle.sv
module op_state_settle #(
  parameter int unsigned SETTLE_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic valid_o,
  output logic done_o
);
  localparam int unsigned CntW = $clog2(SETTLE_CYC + 1);
  localparam logic [CntW-1:0] CntLoad = CntW'(SETTLE_CYC - 1);

  logic [CntW-1:0] cnt_q;
  logic            valid_q;

  assign done_o  = !valid_q && !start_i && (cnt_q == '0);
  assign valid_o = valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      valid_q <= 1'b1;
    end else if (start_i) begin
      cnt_q   <= CntLoad;
      valid_q <= 1'b0;
    end else if (!valid_q) begin
      if (cnt_q == '0) valid_q <= 1'b1;
      else             cnt_q   <= cnt_q - 1'b1;
    end
  end

  // R3
  start_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !valid_o);

  // R3
  fall_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(valid_o) |-> $past(start_i));
endmodule

// File: rtl/op_state_ctrl.sv
module op_state_ctrl
  import op_state_pkg::*;
#(
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned SETTLE_CYC = 4,
  parameter int unsigned STATE_ADDR = 0,
  parameter int unsigned SWRST_ADDR = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              engine_run_o,
  output logic              engine_hold_o,
  output logic              engine_clear_o
);
  localparam logic [ADDR_W-1:0] StAddr = ADDR_W'(STATE_ADDR);
  localparam logic [ADDR_W-1:0] SrAddr = ADDR_W'(SWRST_ADDR);

  op_state_e state_q, req;
  logic rdy_q, err_q, valid, done, legal;
  logic state_wr, swrst, accept, reject, start;
  logic unused_wdata;

  assign unused_wdata = ^reg_wdata_i[DATA_W-1:2];
  assign req      = op_state_e'(reg_wdata_i[1:0]);
  assign state_wr = reg_we_i && (reg_addr_i == StAddr);
  assign swrst    = reg_we_i && (reg_addr_i == SrAddr) && reg_wdata_i[0];
  assign accept   = state_wr && valid && legal;
  assign reject   = state_wr && !(valid && legal);
  assign start    = swrst || accept;

  op_state_legal i_legal (
    .cur_i   (state_q),
    .req_i   (req),
    .legal_o (legal)
  );

  op_state_settle #(.SETTLE_CYC(SETTLE_CYC)) i_settle (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .valid_o (valid),
    .done_o  (done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RESET;
      rdy_q   <= 1'b1;
      err_q   <= 1'b0;
    end else if (swrst) begin
      state_q <= ST_RESET;
      rdy_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (accept) state_q <= req;
      if (done)   rdy_q   <= 1'b1;
      if (reject) err_q   <= 1'b1;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == StAddr) begin
      reg_rdata_o[1:0]       = state_q;
      reg_rdata_o[VALID_BIT] = valid;
      reg_rdata_o[READY_BIT] = rdy_q;
      reg_rdata_o[ERR_BIT]   = err_q;
    end
  end

  // gated on settled state only
  assign engine_run_o   = valid && (state_q == ST_RUN);
  assign engine_hold_o  = valid && (state_q == ST_PAUSE);
  assign engine_clear_o = valid && (state_q == ST_RESET);

  // R5
  illegal_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_wr && valid && !legal) |=> ($stable(state_q) && valid && err_q));

  // R6
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_wr && !valid) |=> ($stable(state_q) && err_q));

  // R7
  swrst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swrst |=> (state_q == ST_RESET && !rdy_q && !err_q && !valid));

  // R8
  rdy_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdy_q && !swrst) |=> rdy_q);

  // R9
  engine_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({engine_run_o, engine_hold_o, engine_clear_o}));
endmodule

// File: tb/test_op_state_ctrl.sv
module test_op_state_ctrl;
  localparam int S = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        run_o, hold_o, clear_o;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  op_state_ctrl #(.SETTLE_CYC(S)) i_op_state_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .engine_run_o(run_o),
    .engine_hold_o(hold_o), .engine_clear_o(clear_o));

  // behavioural reference
  int m_st = 0, m_val = 1, m_cnt = 0, m_rdy = 1, m_err = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_val = 1; m_cnt = 0; m_rdy = 1; m_err = 0;
    end else begin
      bit go, ok;
      go = 0;
      if (we && addr == 1 && wdata[0]) begin
        m_st = 0; m_rdy = 0; m_err = 0; go = 1;
      end else if (we && addr == 0) begin
        int r;
        r = int'(wdata[1:0]);
        ok = (r == 0) || (r == 1 && m_st != 2) || (r == 3 && m_st == 1);
        if (m_val == 1 && ok) begin m_st = r; go = 1; end
        else m_err = 1;
      end
      if (go) begin m_val = 0; m_cnt = S - 1; end
      else if (m_val == 0) begin
        if (m_cnt == 0) begin m_val = 1; m_rdy = 1; end
        else m_cnt--;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int exp_rd;
      exp_rd = (addr == 0) ? (m_st | (m_val << 2) | (m_rdy << 4) | (m_err << 8)) : 0;
      chk(rdata == 32'(exp_rd), "R2 model rdata", int'(rdata), exp_rd);
      chk({run_o, hold_o, clear_o} ==
          {m_val == 1 && m_st == 1, m_val == 1 && m_st == 3, m_val == 1 && m_st == 0},
          "R9 model engine", int'({run_o, hold_o, clear_o}),
          int'({m_val == 1 && m_st == 1, m_val == 1 && m_st == 3, m_val == 1 && m_st == 0}));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected <20000 cycles", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    we = 1; addr = a; wdata = d;
    @(posedge clk); #1;
    we = 0; addr = 0; wdata = '0;
  endtask

  task automatic count_low(output int n, output bit rdy_drop);
    n = 0; rdy_drop = 0;
    forever begin
      @(negedge clk);
      if (!rdata[4]) rdy_drop = 1;
      if (rdata[2]) break;
      n++;
    end
  endtask

  task automatic expect_now(input string tag, input int exp_rd, input bit [2:0] exp_eng);
    @(negedge clk);
    chk(rdata == 32'(exp_rd), tag, int'(rdata), exp_rd);
    chk({run_o, hold_o, clear_o} == exp_eng, tag, int'({run_o, hold_o, clear_o}), int'(exp_eng));
  endtask

  initial begin
    int n;
    bit dr;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    expect_now("R1 reset", 32'h14, 3'b001);
    // R7 soft reset with bit0 clear: no effect
    wr(4'd1, 32'h2);
    expect_now("R7 swrst bit0=0", 32'h14, 3'b001);
    // R5 pause from reset illegal
    wr(4'd0, 32'h3);
    expect_now("R5 pause from reset", 32'h114, 3'b001);
    // R7 soft reset clears error, restarts settle
    wr(4'd1, 32'h1);
    chk(rdata == 32'h0, "R7 swrst state", int'(rdata), 32'h0);
    count_low(n, dr);
    chk(n == S, "R7 swrst settle", n, S);
    expect_now("R7 swrst done", 32'h14, 3'b001);
    // R3 reset -> run
    wr(4'd0, 32'h1);
    chk(rdata == 32'h11, "R3 run pending", int'(rdata), 32'h11);
    chk(!run_o, "R9 run gated", int'(run_o), 0);
    count_low(n, dr);
    chk(n == S, "R3 settle window", n, S);
    expect_now("R3 run settled", 32'h15, 3'b100);
    // R6 write while busy ignored; R8 ready kept
    wr(4'd0, 32'h3);
    wr(4'd0, 32'h1);
    count_low(n, dr);
    chk(!dr, "R8 ready kept", int'(dr), 0);
    expect_now("R6 busy write ignored", 32'h117, 3'b010);
    // R4 pause -> pause illegal
    wr(4'd0, 32'h3);
    expect_now("R4 pause from pause", 32'h117, 3'b010);
    // R5 reserved code
    wr(4'd0, 32'h2);
    expect_now("R5 code 2", 32'h117, 3'b010);
    // R4 pause -> run
    wr(4'd0, 32'h1);
    chk(rdata == 32'h111, "R4 pause->run pending", int'(rdata), 32'h111);
    count_low(n, dr);
    chk(n == S, "R4 settle", n, S);
    expect_now("R4 run", 32'h115, 3'b100);
    // R4 run -> reset
    wr(4'd0, 32'h0);
    count_low(n, dr);
    expect_now("R4 run->reset", 32'h114, 3'b001);
    // R7 soft reset while busy
    wr(4'd0, 32'h1);
    wr(4'd1, 32'h1);
    chk(rdata == 32'h0, "R7 swrst busy", int'(rdata), 32'h0);
    count_low(n, dr);
    chk(n == S, "R7 busy settle", n, S);
    expect_now("R7 busy done", 32'h14, 3'b001);
    // R2 other addresses read zero
    @(posedge clk); #1 addr = 4'd1;
    @(negedge clk); chk(rdata == 0, "R2 addr1", int'(rdata), 0);
    @(posedge clk); #1 addr = 4'd5;
    @(negedge clk); chk(rdata == 0, "R2 addr5", int'(rdata), 0);
    @(posedge clk); #1 addr = 4'd0;
    repeat (2) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule